// File: doc/BRIEF.md
# Tributary Clock Rate and Phase Encoder

This block compares a T1 or E1 tributary clock against a fast reference clock and a 2 kHz frame pulse that is synchronous to the reference. It produces a short link-rate word for each frame period. The span between two frame pulses is one measurement window. During a window the block counts rising edges of the tributary clock. When the window closes, it reports the count as a 2-bit deviation code: on nominal, one above nominal, one below nominal, or out of range.

At the start of each window the block also measures the phase of the tributary clock. It counts reference edges from the frame pulse up to the first tributary rising edge that follows it. This phase value is reported together with the rate code of the same window, so a receiver can rebuild both the frequency and the alignment of the tributary. Each channel can be enabled on its own. The tributary clock is asynchronous and passes through a synchronizer before any edge is counted.

Top module: `trib_rate_phase_enc`

## Requirements
- R1: While rst_n is low, rate_code, phase_cnt, word_valid and rate_alarm are all 0.
- R2: trib_clk passes through two synchronizing flops. A low-to-high change of trib_clk sampled at reference edge k is recognised as a tributary rising edge at edge k+2, provided it was sampled low at edge k-1.
- R3: A window closes at a reference edge where frame_pulse is sampled high after having been sampled low at the previous edge. A tributary rising edge recognised at that same edge counts toward the closing window. The next window starts from zero, and the edge counter saturates at 2047.
- R4: The nominal count is 772 when mode_e1 is 0 (T1) and 1024 when mode_e1 is 1 (E1). mode_e1 is sampled at the edge that closes the window.
- R5: rate_code is 2'b00 when the count equals nominal, 2'b01 when it is nominal+1, and 2'b10 when it is nominal-1.
- R6: Any other count gives rate_code 2'b11 with rate_alarm 1. rate_alarm updates only with each word, so it returns to 0 at the next word that is in range.
- R7: The phase value is the number of reference edges after the window-opening edge, up to and including the edge at which the first tributary rising edge is recognised. A rising edge recognised at the opening edge itself is not used.
- R8: If no tributary rising edge is recognised, the phase value saturates at 63.
- R9: word_valid is high for exactly one cycle, right after a closing edge. It is raised only if the closing window was opened by an earlier frame pulse with chan_en high. The first frame pulse after reset or enable only opens a window.
- R10: While chan_en is low, no word is produced and the window and phase measurements are discarded. rate_code, phase_cnt and rate_alarm hold their last values.
- R11: The phase_cnt value reported with a word is the value measured at the start of the window that the word closes. All three output fields change only together with word_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all logic is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame pulse, synchronous to ref_clk; its rising edge bounds the windows |
| trib_clk | input | 1 | Asynchronous T1 or E1 tributary clock |
| mode_e1 | input | 1 | 0 selects T1 nominal (772), 1 selects E1 nominal (1024) |
| chan_en | input | 1 | Channel enable; low discards measurement and suppresses words |
| rate_code | output | 2 | Deviation code of the last reported window |
| phase_cnt | output | 6 | Phase value of the last reported window |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| rate_alarm | output | 1 | High when the last word was out of range |

## Verification
The hardest cases to reach from the ports are a window that lands exactly on nominal or one count away from it, and a window in which the tributary clock never rises, so that the phase saturates. To get there, the stimulus builds each window's tributary waveform from an integer schedule that places exactly N rising edges in a frame period, with N chosen per window. Because the first edge of each window falls past the synchronizer delay, every count is exact. A window with N of zero drives the phase counter into saturation, and an E1 window run with the T1 rate reaches the out-of-range code. A behavioural model tracks the synchronizer delay with a sample queue and is compared with every output on every cycle.

// File: rtl/trpe_pkg.sv
package trpe_pkg;
  localparam int CNT_W = 11;
  localparam int PH_W  = 6;

  typedef enum logic [1:0] {
    RC_NOMINAL      = 2'b00,
    RC_PLUS_ONE     = 2'b01,
    RC_MINUS_ONE    = 2'b10,
    RC_OUT_OF_RANGE = 2'b11
  } rate_code_t;

  // Deviation of a window count from the nominal value
  function automatic rate_code_t rc_encode(input logic [CNT_W-1:0] cnt,
                                           input logic [CNT_W-1:0] nom);
    logic [CNT_W:0] a;
    logic [CNT_W:0] b;
    a = {1'b0, cnt};
    b = {1'b0, nom};
    if (a == b)             return RC_NOMINAL;
    else if (a == b + 1'b1) return RC_PLUS_ONE;
    else if (a + 1'b1 == b) return RC_MINUS_ONE;
    else                    return RC_OUT_OF_RANGE;
  endfunction
endpackage

// File: rtl/trpe_edge_sync.sv
module trpe_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  // STAGES synchronizing flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  logic lvl_now, lvl_prev;
  assign lvl_now  = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];
  assign rise_o   = lvl_now & ~lvl_prev;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  // R2
  rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(async_in, STAGES));
endmodule

// File: rtl/trpe_tick_window.sv
module trpe_tick_window #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         close_i,
  input  logic         rise_i,
  output logic [W-1:0] total_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = (rise_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  assign total_o = cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr || close_i)   cnt_q <= '0;
    else                       cnt_q <= cnt_inc;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !close_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !close_i) |=> (cnt_q - $past(cnt_q)) <= W'(1));
endmodule

// File: rtl/trpe_phase_meas.sv
module trpe_phase_meas #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start_i,
  input  logic         rise_i,
  output logic [W-1:0] phase_o,
  output logic         busy_o
);
  localparam logic [W-1:0] PH_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= '0;
      busy_o  <= 1'b0;
    end else if (clr) begin
      phase_o <= '0;
      busy_o  <= 1'b0;
    end else if (start_i) begin
      phase_o <= '0;
      busy_o  <= 1'b1;
    end else if (busy_o) begin
      if (phase_o != PH_MAX) phase_o <= phase_o + 1'b1;
      if (rise_i)            busy_o  <= 1'b0;
    end
  end

  // R8
  phase_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && phase_o == PH_MAX && !start_i && !clr) |=> phase_o == PH_MAX);
  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !clr) |=> $stable(phase_o));
endmodule

// File: rtl/trib_rate_phase_enc.sv
module trib_rate_phase_enc #(
  parameter int NOM_T1      = 772,
  parameter int NOM_E1      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       frame_pulse,
  input  logic       trib_clk,
  input  logic       mode_e1,
  input  logic       chan_en,
  output logic [1:0] rate_code,
  output logic [5:0] phase_cnt,
  output logic       word_valid,
  output logic       rate_alarm
);
  import trpe_pkg::*;

  localparam logic [CNT_W-1:0] NOM_T1_V = CNT_W'(NOM_T1);
  localparam logic [CNT_W-1:0] NOM_E1_V = CNT_W'(NOM_E1);

  // frame pulse edge
  logic fp_q;
  logic fp_evt;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) fp_q <= 1'b0;
    else        fp_q <= frame_pulse;
  end
  assign fp_evt = frame_pulse & ~fp_q;

  // named internal events
  logic trib_rise;
  logic meas_clr;
  logic win_close;
  logic armed_q;
  logic word_fire;

  assign meas_clr  = ~chan_en;
  assign win_close = chan_en & fp_evt;
  assign word_fire = win_close & armed_q;

  trpe_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(ref_clk), .rst_n(rst_n), .async_in(trib_clk), .rise_o(trib_rise)
  );

  logic [CNT_W-1:0] win_total;
  trpe_tick_window #(.W(CNT_W)) win_i (
    .clk(ref_clk), .rst_n(rst_n), .clr(meas_clr), .close_i(win_close),
    .rise_i(trib_rise), .total_o(win_total)
  );

  logic [PH_W-1:0] ph_val;
  logic            ph_busy;
  trpe_phase_meas #(.W(PH_W)) ph_i (
    .clk(ref_clk), .rst_n(rst_n), .clr(meas_clr), .start_i(win_close),
    .rise_i(trib_rise), .phase_o(ph_val), .busy_o(ph_busy)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (!chan_en)  armed_q <= 1'b0;
    else if (fp_evt)    armed_q <= 1'b1;
  end

  rate_code_t code_now;
  assign code_now = rc_encode(win_total, mode_e1 ? NOM_E1_V : NOM_T1_V);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code  <= 2'b00;
      phase_cnt  <= '0;
      word_valid <= 1'b0;
      rate_alarm <= 1'b0;
    end else begin
      word_valid <= word_fire;
      if (word_fire) begin
        rate_code  <= code_now;
        phase_cnt  <= ph_val;
        rate_alarm <= (code_now == RC_OUT_OF_RANGE);
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R9
  first_window_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    word_valid |-> $past(armed_q));
  // R10
  disabled_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !chan_en |=> !word_valid);
  // R6
  alarm_code_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    word_valid |-> (rate_alarm == (rate_code == 2'b11)));
  // R11
  out_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !word_valid |-> ($stable(rate_code) && $stable(phase_cnt) && $stable(rate_alarm)));
endmodule

// File: tb/trib_rate_phase_enc_tb.sv
module trib_rate_phase_enc_tb_top;
  localparam int WIN = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       trib_clk = 1'b0;
  logic       mode_e1 = 1'b0;
  logic       chan_en = 1'b0;
  logic [1:0] rate_code;
  logic [5:0] phase_cnt;
  logic       word_valid;
  logic       rate_alarm;

  always #5 clk = ~clk;

  trib_rate_phase_enc dut_i (
    .ref_clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .trib_clk(trib_clk), .mode_e1(mode_e1), .chan_en(chan_en),
    .rate_code(rate_code), .phase_cnt(phase_cnt),
    .word_valid(word_valid), .rate_alarm(rate_alarm)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int seen_code [4] = '{0, 0, 0, 0};
  int seen_sat = 0;
  int n_words = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int hist[$];
  int fp_prev = 0, started = 0, cnt = 0, pc = 0, prun = 0;
  int e_code = 0, e_phase = 0, e_valid = 0, e_alarm = 0;

  function automatic int expect_code(int c, int nom);
    if (c == nom)          return 0;
    else if (c == nom + 1) return 1;
    else if (c == nom - 1) return 2;
    else                   return 3;
  endfunction

  always @(posedge clk) begin
    int rise, fpe;
    if (!rst_n) begin
      hist = {0, 0, 0};
      fp_prev = 0; started = 0; cnt = 0; pc = 0; prun = 0;
      e_code = 0; e_phase = 0; e_valid = 0; e_alarm = 0;
    end else begin
      hist.push_back(int'(trib_clk));
      if (hist.size() > 4) void'(hist.pop_front());
      rise = (hist[hist.size()-3] == 1 && hist[hist.size()-4] == 0) ? 1 : 0;
      fpe = (frame_pulse && !fp_prev) ? 1 : 0;
      fp_prev = int'(frame_pulse);
      if (!chan_en) begin
        started = 0; cnt = 0; pc = 0; prun = 0; e_valid = 0;
      end else if (fpe) begin
        if (started) begin
          e_code  = expect_code(cnt + rise, mode_e1 ? 1024 : 772);
          e_phase = pc;
          e_alarm = (e_code == 3);
          e_valid = 1;
        end else e_valid = 0;
        started = 1; cnt = 0; pc = 0; prun = 1;
      end else begin
        e_valid = 0;
        cnt = (cnt + rise > 2047) ? 2047 : cnt + rise;
        if (prun) begin
          if (rise) begin
            pc = (pc + 1 > 63) ? 63 : pc + 1;
            prun = 0;
          end else if (pc < 63) pc = pc + 1;
        end
      end
    end
  end

  task automatic compare_all();
    chk("R9 word_valid", int'(word_valid), e_valid);
    chk("R5 rate_code", int'(rate_code), e_code);
    chk("R7 phase_cnt", int'(phase_cnt), e_phase);
    chk("R6 rate_alarm", int'(rate_alarm), e_alarm);
    if (word_valid) begin
      n_words++;
      seen_code[rate_code]++;
      if (phase_cnt == 6'd63) seen_sat++;
    end
  endtask

  // one window with exactly n rising tributary edges
  task automatic run_window(input bit e1, input int n, input bit en);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      compare_all();
      frame_pulse = (i == 0);
      if (i == 0) chan_en = en;
      if (i == 1) mode_e1 = e1;
      trib_clk = (((i * 2 * n) / WIN) % 2) == 1;
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      // R1 reset state
      chk("R1 rate_code", int'(rate_code), 0);
      chk("R1 phase_cnt", int'(phase_cnt), 0);
      chk("R1 word_valid", int'(word_valid), 0);
      chk("R1 rate_alarm", int'(rate_alarm), 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_window(0, 772, 1);   // opens only (R9)
    run_window(0, 772, 1);   // R4 T1 nominal
    run_window(0, 773, 1);   // R5 plus one
    run_window(0, 771, 1);   // R5 minus one
    run_window(0, 700, 1);   // R6 out of range
    run_window(1, 1024, 1);  // R4 E1 nominal, alarm clears
    run_window(1, 1025, 1);
    run_window(1, 1023, 1);
    run_window(1, 772, 1);   // R4 T1 rate judged in E1 mode
    run_window(0, 772, 1);
    run_window(0, 0, 0);     // R10 disabled
    run_window(0, 772, 1);   // re-arm
    run_window(0, 0, 1);     // R8 no tributary edge
    run_window(0, 772, 1);
    run_window(0, 772, 1);
    repeat (10) begin
      @(negedge clk);
      compare_all();
    end
    // coverage of word kinds
    chk("R5 nominal words seen", int'(seen_code[0] >= 4), 1);
    chk("R5 plus-one words seen", int'(seen_code[1] >= 2), 1);
    chk("R5 minus-one words seen", int'(seen_code[2] >= 2), 1);
    chk("R6 out-of-range words seen", int'(seen_code[3] >= 3), 1);
    chk("R8 saturated phase seen", int'(seen_sat >= 1), 1);
    chk("R9 R10 word count", n_words, 12);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule